// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block forms the operand address for the "address register indirect with 8-bit displacement and index" mode. A request carries the base address register, the 16-bit brief extension word, the eight data registers, the eight address registers and the operand size code. The block decodes the extension word and picks the index register and its width. It adds base, displacement and index with no scale factor. It returns the full 32-bit sum, the 24-bit address that reaches the bus, and a flag that marks a misaligned word or long access.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, one clock after acceptance. The output register holds one result. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is taken. The full 32-bit sum is kept next to the truncated bus address so that fault handling can report the upper byte that never reaches the bus.

Top module: `idx_ea_unit`

## Requirements
- R1: The displacement is extension word bits 7:0, sign-extended to 32 bits (0x4F gives +0x4F, 0x80 gives -0x80).
- R2: Extension word bit 15 picks the index bank: 0 picks a data register and 1 picks an address register. Bits 14:12 give the register number 0 to 7.
- R3: Extension word bit 11 sets the index width. When it is 0, the index is the low 16 bits of the chosen register, sign-extended. When it is 1, the index is all 32 bits.
- R4: `ea_full` equals base + displacement + index modulo 2^32, with no scaling of the index.
- R5: `bus_addr` equals bits 23:0 of `ea_full`.
- R6: Size codes are 00 byte, 01 word and 10 long, and 11 is handled like long. For any non-byte code, `addr_fault` is 1 exactly when bit 0 of the address is 1.
- R7: A byte access (size 00) never sets `addr_fault`, whether the address is odd or even.
- R8: A request accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `ea_full`, `bus_addr` and `addr_fault` hold their values.
- R10: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| base_addr | input | 32 | Base address register value |
| ext_word | input | 16 | Brief extension word |
| data_regs | input | 256 | Data registers 0..7, register n at bits 32n+31:32n |
| addr_regs | input | 256 | Address registers 0..7, register n at bits 32n+31:32n |
| op_size | input | 2 | Operand size code (00 byte, 01 word, 10 long) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| ea_full | output | 32 | Full 32-bit effective address |
| bus_addr | output | 24 | Truncated bus address |
| addr_fault | output | 1 | Odd address on a word or long access |

## Verification
The assertions assume that the request fields are stable and meaningful in any cycle where `in_valid` and `in_ready` are both high. They also assume that `out_ready` is a plain level input with no link to `in_valid`. The stimulus changes inputs only on the falling edge. It chooses `in_valid` and `out_ready` on their own so that stalls, back-to-back transfers and idle gaps all occur. It uses only the size codes 00, 01 and 10, and the register contents cover both signs for the low-half and full-width index forms.

// File: rtl/idx_ea_pkg.sv
`timescale 1ns/1ps
package idx_ea_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } op_size_e;

  // Field positions inside the brief extension word
  localparam int unsigned EXT_BANK_BIT = 15;
  localparam int unsigned EXT_NUM_MSB  = 14;
  localparam int unsigned EXT_LONG_BIT = 11;

  typedef struct packed {
    logic       use_addr;
    logic [2:0] reg_num;
    logic       full_width;
  } idx_sel_t;
endpackage

// File: rtl/idx_ext_decode.sv
`timescale 1ns/1ps
module idx_ext_decode
  import idx_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXT_W  = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [EXT_W-1:0]  ext_word,
  output logic [ADDR_W-1:0] disp_ext,
  output idx_sel_t          sel
);
  localparam int unsigned PAD_W = ADDR_W - DISP_W;
  localparam int unsigned GAP_W = EXT_LONG_BIT - DISP_W;

  logic unused_gap;
  assign unused_gap = ^ext_word[EXT_LONG_BIT-1 -: GAP_W];

  always_comb begin
    disp_ext        = {{PAD_W{ext_word[DISP_W-1]}}, ext_word[DISP_W-1:0]};
    sel.use_addr    = ext_word[EXT_BANK_BIT];
    sel.reg_num     = ext_word[EXT_NUM_MSB -: 3];
    sel.full_width  = ext_word[EXT_LONG_BIT];
  end
endmodule

// File: rtl/idx_reg_select.sv
`timescale 1ns/1ps
module idx_reg_select
  import idx_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic [NREGS*ADDR_W-1:0] data_regs,
  input  logic [NREGS*ADDR_W-1:0] addr_regs,
  input  idx_sel_t                sel,
  output logic [ADDR_W-1:0]       index
);
  localparam int unsigned EXT_W = ADDR_W - HALF_W;

  logic [ADDR_W-1:0] dreg [NREGS];
  logic [ADDR_W-1:0] areg [NREGS];
  logic [ADDR_W-1:0] picked;

  for (genvar g = 0; g < NREGS; g++) begin : g_unpack
    assign dreg[g] = data_regs[g*ADDR_W +: ADDR_W];
    assign areg[g] = addr_regs[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    picked = sel.use_addr ? areg[sel.reg_num] : dreg[sel.reg_num];
    if (sel.full_width) index = picked;
    else                index = {{EXT_W{picked[HALF_W-1]}}, picked[HALF_W-1:0]};
  end
endmodule

// File: rtl/idx_ea_adder.sv
`timescale 1ns/1ps
module idx_ea_adder
  import idx_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 24
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] index,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] ea,
  output logic [BUS_W-1:0]  bus,
  output logic              fault
);
  always_comb begin
    ea    = base + disp + index;
    bus   = ea[BUS_W-1:0];
    fault = (size != SZ_BYTE) && bus[0];
  end
endmodule

// File: rtl/idx_ea_unit.sv
`timescale 1ns/1ps
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 24,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned EXT_W  = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic [EXT_W-1:0]        ext_word,
  input  logic [NREGS*ADDR_W-1:0] data_regs,
  input  logic [NREGS*ADDR_W-1:0] addr_regs,
  input  logic [1:0]              op_size,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       ea_full,
  output logic [BUS_W-1:0]        bus_addr,
  output logic                    addr_fault
);
  logic [ADDR_W-1:0] disp_ext, index, ea_d;
  logic [BUS_W-1:0]  bus_d;
  logic              fault_d;
  idx_sel_t          sel;
  logic [1:0]        size_q;
  logic              accept;

  idx_ext_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .DISP_W(DISP_W)) u_dec (
    .ext_word(ext_word), .disp_ext(disp_ext), .sel(sel)
  );

  idx_reg_select #(.ADDR_W(ADDR_W), .NREGS(NREGS), .HALF_W(HALF_W)) u_sel (
    .data_regs(data_regs), .addr_regs(addr_regs), .sel(sel), .index(index)
  );

  idx_ea_adder #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_add (
    .base(base_addr), .disp(disp_ext), .index(index), .size(op_size),
    .ea(ea_d), .bus(bus_d), .fault(fault_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ea_full    <= '0;
      bus_addr   <= '0;
      addr_fault <= 1'b0;
      size_q     <= SZ_BYTE;
    end else if (accept) begin
      out_valid  <= 1'b1;
      ea_full    <= ea_d;
      bus_addr   <= bus_d;
      addr_fault <= fault_d;
      size_q     <= op_size;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_accept_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ea_full) &&
                                   $stable(bus_addr) && $stable(addr_fault)));

  assert_bus_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (bus_addr == ea_full[BUS_W-1:0]));

  assert_fault_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && addr_fault) |-> bus_addr[0]);

  assert_byte_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && size_q == SZ_BYTE) |-> !addr_fault);
endmodule

// File: tb/idx_ea_unit_tb.sv
`timescale 1ns/1ps
module idx_ea_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, addr_fault;
  logic [31:0] base_addr = '0, ea_full;
  logic [15:0] ext_word = '0;
  logic [1:0]  op_size = '0;
  logic [23:0] bus_addr;
  logic [31:0] dr [8];
  logic [31:0] ar [8];
  logic [255:0] data_regs, addr_regs;

  int checks = 0, fails = 0;
  bit m_valid = 1'b0;
  logic [31:0] m_ea = '0;
  logic m_fault = 1'b0;
  logic [1:0] m_size = '0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_flat
    assign data_regs[g*32 +: 32] = dr[g];
    assign addr_regs[g*32 +: 32] = ar[g];
  end

  idx_ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_addr(base_addr), .ext_word(ext_word), .data_regs(data_regs),
    .addr_regs(addr_regs), .op_size(op_size), .out_valid(out_valid),
    .out_ready(out_ready), .ea_full(ea_full), .bus_addr(bus_addr),
    .addr_fault(addr_fault)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ea(logic [31:0] b, logic [15:0] x);
    int signed disp;
    logic [31:0] r;
    int signed idx;
    disp = int'($signed(x[7:0]));
    r = x[15] ? ar[x[14:12]] : dr[x[14:12]];
    if (x[11]) idx = int'(r);
    else       idx = int'($signed(r[15:0]));
    return b + 32'(disp) + 32'(idx);
  endfunction

  // One clock: drive at falling edge, predict, check after the rise
  task automatic cycle(string tag, bit iv, logic [31:0] b, logic [15:0] x,
                       logic [1:0] sz, bit ordy);
    bit acc;
    in_valid = iv; base_addr = b; ext_word = x; op_size = sz; out_ready = ordy;
    #1;
    check("R9 in_ready", 32'(in_ready), 32'(!m_valid || ordy));
    acc = iv && (!m_valid || ordy);
    @(posedge clk);
    if (acc) begin
      m_valid = 1'b1;
      m_ea    = ref_ea(b, x);
      m_size  = sz;
      m_fault = (sz != 2'b00) && m_ea[0];
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    check("R8 out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      check({tag, " R4 ea_full"}, ea_full, m_ea);
      check("R5 bus_addr", 32'(bus_addr), 32'(m_ea[23:0]));
      if (m_size == 2'b00) check("R7 byte fault", 32'(addr_fault), 32'(1'b0));
      else                 check("R6 fault", 32'(addr_fault), 32'(m_fault));
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      dr[i] = 32'h1000_0000 * i + 32'h0000_8421 * i;
      ar[i] = 32'h0101_0101 * (i + 1);
    end
    dr[0] = 32'ha1e9_40b7;
    dr[3] = 32'h1234_8000;
    ar[5] = 32'hfedc_ba98;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", 32'(out_valid), 32'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", 32'(out_valid), 32'(1'b0));

    cycle("R4 odd long",  1, 32'h3e4d_4a5b, 16'h0c4f, 2'b10, 1);
    check("R4 literal", ea_full, 32'he036_8b61);
    check("R5 literal", 32'(bus_addr), 32'h0036_8b61);
    check("R6 literal", 32'(addr_fault), 32'(1'b1));
    cycle("R7 odd byte",  1, 32'h3e4d_4a5b, 16'h0c4f, 2'b00, 1);
    check("R7 literal", 32'(addr_fault), 32'(1'b0));
    cycle("R1 neg disp",  1, 32'h0000_1000, 16'h0080, 2'b01, 1);
    check("R1 literal", ea_full, 32'h0000_1000 - 32'h80 + 32'h40b7);
    cycle("R3 word idx",  1, 32'h0002_0000, 16'h3002, 2'b01, 1);
    check("R3 literal", ea_full, 32'h0002_0000 + 32'h2 - 32'h8000);
    cycle("R3 long idx",  1, 32'h0002_0000, 16'h3802, 2'b10, 1);
    cycle("R2 addr bank", 1, 32'h0000_0010, 16'hd804, 2'b01, 1);
    check("R2 literal", ea_full, 32'h0000_0014 + 32'hfedc_ba98);
    cycle("R2 word addr", 1, 32'h0000_0011, 16'hd004, 2'b10, 1);

    // Back-pressure: stall with a pending request, then release
    cycle("R9 load",  1, 32'h0000_0101, 16'h0001, 2'b01, 0);
    cycle("R9 stall", 1, 32'h0000_0200, 16'h0002, 2'b01, 0);
    cycle("R9 stall", 1, 32'h0000_0300, 16'h0003, 2'b10, 0);
    cycle("R9 drain", 1, 32'h0000_0400, 16'h0004, 2'b10, 1);
    cycle("R8 idle",  0, 32'h0, 16'h0, 2'b00, 1);

    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin
        for (int i = 0; i < 8; i++) begin
          dr[i] = $urandom;
          ar[i] = $urandom;
        end
      end
      cycle("rand", ($urandom % 4) != 0, $urandom, 16'($urandom),
            2'($urandom % 3), ($urandom % 3) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule